// File: doc/BRIEF.md
# Shared Buffer Pool Allocator

This block hands out a small pool of identical buffers to several processing clients. Each client raises a request line and holds it. When a buffer is free, the client receives a one-cycle grant pulse carrying the index of the buffer it now owns. The block records one owner, or none, for every buffer. A client may own several buffers at once and may ask for more while it holds some. A request that finds the pool empty gets no answer and stays pending. The client is stalled until some buffer comes free.

A holder finishes with a buffer in one of two ways. It can return the buffer to the free pool. It can instead pass ownership to a destination client fixed for it at design time by a parameter table. A pass never goes through the free state. The buffer contents live outside this block and are not moved, so only the ownership record changes. Returns that name a buffer the client does not own are dropped and flagged.

When more clients compete than there are free buffers, a round-robin pointer over the clients picks the winners.

Top module: `buf_pool_alloc`

## Requirements
- R1: After a synchronous active-high reset, all buffers are free, `free_cnt_o` equals N, and `gnt_o` and `err_o` are all zero.
- R2: A request sampled on a clock edge while at least one buffer is free yields a one-cycle `gnt_o` pulse after that edge. The pulse carries the index of the lowest-numbered free buffer on `gnt_idx_o` (slice `c*BW +: BW` for client c).
- R3: While no buffer is free, a pending request receives no grant and stays pending. No grant is lost once a buffer comes free later.
- R4: A buffer returned or passed on a clock edge is recorded at that edge. It can be granted to a pending requester at the following edge at the earliest, never at the same edge.
- R5: A return with mode 0 (`ret_mode_i[c]=0`) by the owner frees the buffer, and `free_cnt_o` rises by one after that edge.
- R6: A return with mode 1 by the owner moves ownership to the client named in that owner's slice of `PASS_DEST`. The default is client c passes to client (c+1) mod M. `free_cnt_o` is unchanged, and only the new owner can then return the buffer.
- R7: A return that names a buffer the client does not own changes no ownership and no count. It gives a one-cycle pulse on that client's `err_o` bit after the edge.
- R8: A client that already owns buffers can be granted further buffers.
- R9: Requests from several clients on the same edge are all granted on that edge while free buffers remain, each with a distinct buffer index.
- R10: When requesters outnumber free buffers, clients are served in round-robin order starting at a pointer (0 after reset). After any grant, the pointer moves to the client after the last one granted.
- R11: A client granted at one edge is not eligible at the next edge, even if its request line stays high. A held request therefore gets at most one grant every two cycles.
- R12: `free_cnt_o` always equals the number of unowned buffers after the latest edge, and never exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | M | Per-client buffer request level |
| ret_vld_i | input | M | Per-client return strobe |
| ret_mode_i | input | M | Per-client return mode: 0 free to pool, 1 pass to fixed destination |
| ret_idx_i | input | M*BW | Per-client buffer index being returned |
| gnt_o | output | M | Per-client one-cycle grant pulse |
| gnt_idx_o | output | M*BW | Per-client granted buffer index |
| err_o | output | M | Per-client one-cycle pulse for a rejected return |
| free_cnt_o | output | FREE_W | Number of unowned buffers |

## Verification
The hardest case to reach is round-robin selection under scarcity. It needs the pool fully drained while several clients keep requests pending, and then buffers coming free one at a time. The stimulus first grants all four buffers at once. Every client then requests again against an empty pool, and single buffers are freed by their current owners. Each step shows which pending client the rotating pointer picks. The pass-then-return sequence and the held-request case are driven the same way. A behavioural model tracks owners in integer arrays and predicts every output on every clock.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic {
    RET_FREE = 1'b0,
    RET_PASS = 1'b1
  } ret_mode_e;
endpackage

// File: rtl/bpa_popcnt.sv
module bpa_popcnt #(
  parameter int N = 4,
  parameter int W = 3
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + W'(vec_i[i]);
    end
  end
endmodule

// File: rtl/bpa_alloc.sv
module bpa_alloc #(
  parameter int M  = 4,
  parameter int N  = 4,
  parameter int CW = 2,
  parameter int BW = 2
) (
  input  logic [M-1:0]    elig_i,
  input  logic [N-1:0]    free_i,
  input  logic [CW-1:0]   ptr_i,
  output logic [M-1:0]    gnt_o,
  output logic [M*BW-1:0] gidx_o,
  output logic [N-1:0]    take_o,
  output logic [N*CW-1:0] take_cli_o,
  output logic [CW-1:0]   ptr_nxt_o
);
  logic [N-1:0] avail;
  int           cli;
  int           pick;

  always_comb begin
    avail      = free_i;
    gnt_o      = '0;
    gidx_o     = '0;
    take_o     = '0;
    take_cli_o = '0;
    ptr_nxt_o  = ptr_i;
    cli        = 0;
    pick       = 0;
    for (int k = 0; k < M; k++) begin
      cli = (int'(ptr_i) + k) % M;
      if (elig_i[cli] && (avail != '0)) begin
        pick = 0;
        for (int b = N - 1; b >= 0; b--) begin
          if (avail[b]) pick = b;
        end
        gnt_o[cli]                  = 1'b1;
        gidx_o[cli*BW +: BW]        = BW'(pick);
        avail[pick]                 = 1'b0;
        take_o[pick]                = 1'b1;
        take_cli_o[pick*CW +: CW]   = CW'(cli);
        ptr_nxt_o                   = CW'((cli + 1) % M);
      end
    end
  end
endmodule

// File: rtl/bpa_owner.sv
module bpa_owner
  import bpa_pkg::*;
#(
  parameter int                M    = 4,
  parameter int                N    = 4,
  parameter int                CW   = 2,
  parameter int                BW   = 2,
  parameter logic [M*CW-1:0]   DEST = 8'b00_11_10_01
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [M-1:0]    ret_vld_i,
  input  logic [M-1:0]    ret_mode_i,
  input  logic [M*BW-1:0] ret_idx_i,
  input  logic [N-1:0]    take_i,
  input  logic [N*CW-1:0] take_cli_i,
  output logic [N-1:0]    own_vld_o,
  output logic [N-1:0]    own_vld_nxt_o,
  output logic [M-1:0]    err_nxt_o
);
  logic [N-1:0]    vld_q, vld_d;
  logic [N*CW-1:0] id_q, id_d;
  int              bi;

  always_comb begin
    vld_d     = vld_q;
    id_d      = id_q;
    err_nxt_o = '0;
    bi        = 0;
    // returns act on the state held before this edge
    for (int c = 0; c < M; c++) begin
      if (ret_vld_i[c]) begin
        bi = int'(ret_idx_i[c*BW +: BW]);
        if (bi < N && vld_q[bi] && id_q[bi*CW +: CW] == CW'(c)) begin
          if (ret_mode_e'(ret_mode_i[c]) == RET_PASS) begin
            id_d[bi*CW +: CW] = DEST[c*CW +: CW];
          end else begin
            vld_d[bi] = 1'b0;
          end
        end else begin
          err_nxt_o[c] = 1'b1;
        end
      end
    end
    // new grants only touch buffers that were free
    for (int b = 0; b < N; b++) begin
      if (take_i[b]) begin
        vld_d[b]          = 1'b1;
        id_d[b*CW +: CW]  = take_cli_i[b*CW +: CW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      id_q  <= '0;
    end else begin
      vld_q <= vld_d;
      id_q  <= id_d;
    end
  end

  assign own_vld_o     = vld_q;
  assign own_vld_nxt_o = vld_d;
endmodule

// File: rtl/buf_pool_alloc.sv
module buf_pool_alloc #(
  parameter int              M      = 4,
  parameter int              N      = 4,
  parameter int              CLI_W  = (M > 1) ? $clog2(M) : 1,
  parameter int              BW     = (N > 1) ? $clog2(N) : 1,
  parameter int              FREE_W = $clog2(N + 1),
  parameter logic [M*CLI_W-1:0] PASS_DEST = 8'b00_11_10_01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [M-1:0]      req_i,
  input  logic [M-1:0]      ret_vld_i,
  input  logic [M-1:0]      ret_mode_i,
  input  logic [M*BW-1:0]   ret_idx_i,
  output logic [M-1:0]      gnt_o,
  output logic [M*BW-1:0]   gnt_idx_o,
  output logic [M-1:0]      err_o,
  output logic [FREE_W-1:0] free_cnt_o
);
  logic [M-1:0]      gnt_q, a_gnt, err_d, err_q;
  logic [M*BW-1:0]   idx_q, a_idx;
  logic [N-1:0]      own_vld, own_vld_nxt, take;
  logic [N*CLI_W-1:0] take_cli;
  logic [CLI_W-1:0]  ptr_q, ptr_nxt;
  logic [FREE_W-1:0] free_q, free_nxt;
  logic [M-1:0]      elig;

  assign elig = req_i & ~gnt_q;

  bpa_alloc #(.M(M), .N(N), .CW(CLI_W), .BW(BW)) alloc_i (
    .elig_i     (elig),
    .free_i     (~own_vld),
    .ptr_i      (ptr_q),
    .gnt_o      (a_gnt),
    .gidx_o     (a_idx),
    .take_o     (take),
    .take_cli_o (take_cli),
    .ptr_nxt_o  (ptr_nxt)
  );

  bpa_owner #(.M(M), .N(N), .CW(CLI_W), .BW(BW), .DEST(PASS_DEST)) owner_i (
    .clk           (clk),
    .rst           (rst),
    .ret_vld_i     (ret_vld_i),
    .ret_mode_i    (ret_mode_i),
    .ret_idx_i     (ret_idx_i),
    .take_i        (take),
    .take_cli_i    (take_cli),
    .own_vld_o     (own_vld),
    .own_vld_nxt_o (own_vld_nxt),
    .err_nxt_o     (err_d)
  );

  bpa_popcnt #(.N(N), .W(FREE_W)) cnt_i (
    .vec_i (~own_vld_nxt),
    .cnt_o (free_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      idx_q  <= '0;
      err_q  <= '0;
      free_q <= FREE_W'(N);
      ptr_q  <= '0;
    end else begin
      gnt_q  <= a_gnt;
      idx_q  <= a_idx;
      err_q  <= err_d;
      free_q <= free_nxt;
      ptr_q  <= ptr_nxt;
    end
  end

  assign gnt_o      = gnt_q;
  assign gnt_idx_o  = idx_q;
  assign err_o      = err_q;
  assign free_cnt_o = free_q;
endmodule

// File: rtl/bpa_chk.sv
module bpa_chk #(
  parameter int M  = 4,
  parameter int N  = 4,
  parameter int FW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [M-1:0]  req_i,
  input logic [M-1:0]  ret_vld_i,
  input logic [M-1:0]  gnt_o,
  input logic [M-1:0]  err_o,
  input logic [FW-1:0] free_cnt_o
);
  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & ~$past(req_i)) == '0);
  // R2
  grant_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(free_cnt_o) != '0) && (($past(req_i) & ~$past(gnt_o)) != '0)) |-> (gnt_o != '0));
  // R3
  no_overgrant_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt_o) <= int'($past(free_cnt_o)));
  // R11
  no_repeat_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o & $past(gnt_o)) == '0);
  // R7
  err_needs_return_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o & ~$past(ret_vld_i)) == '0);
  // R12
  free_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt_o) <= N);
endmodule

bind buf_pool_alloc bpa_chk #(.M(M), .N(N), .FW(FREE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .ret_vld_i  (ret_vld_i),
  .gnt_o      (gnt_o),
  .err_o      (err_o),
  .free_cnt_o (free_cnt_o)
);

// File: tb/buf_pool_alloc_tb_top.sv
module buf_pool_alloc_tb_top;
  localparam int M  = 4;
  localparam int N  = 4;
  localparam int BW = 2;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [M-1:0]  req_i = '0, ret_vld_i = '0, ret_mode_i = '0;
  logic [M*BW-1:0] ret_idx_i = '0;
  logic [M-1:0]  gnt_o, err_o;
  logic [M*BW-1:0] gnt_idx_o;
  logic [FW-1:0] free_cnt_o;

  int checks = 0;
  int fails  = 0;

  int           m_own [N];
  int           m_ptr;
  logic [M-1:0] m_gprev;
  logic [M-1:0] pend, sticky, rv, rm;
  int           ri [M];

  always #5 clk = ~clk;

  buf_pool_alloc dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .ret_vld_i(ret_vld_i),
    .ret_mode_i(ret_mode_i), .ret_idx_i(ret_idx_i), .gnt_o(gnt_o),
    .gnt_idx_o(gnt_idx_o), .err_o(err_o), .free_cnt_o(free_cnt_o)
  );

  function automatic int dest_of(int c);
    return (c + 1) % M;
  endfunction

  function automatic int owned_by(int c);
    for (int b = 0; b < N; b++) if (m_own[b] == c) return b;
    return -1;
  endfunction

  task automatic step(string tag);
    int           own_n [N];
    logic [M-1:0] e_gnt, e_err, elig;
    int           e_idx [M];
    int           e_free, e_ptr, cli, pk;
    logic         bad;
    @(negedge clk);
    req_i = pend; ret_vld_i = rv; ret_mode_i = rm;
    for (int c = 0; c < M; c++) ret_idx_i[c*BW +: BW] = BW'(ri[c]);
    for (int b = 0; b < N; b++) own_n[b] = m_own[b];
    e_gnt = '0; e_err = '0; e_ptr = m_ptr;
    for (int c = 0; c < M; c++) e_idx[c] = 0;
    elig = pend & ~m_gprev;
    for (int k = 0; k < M; k++) begin
      cli = (m_ptr + k) % M;
      pk = -1;
      for (int b = 0; b < N; b++) if (pk < 0 && m_own[b] == -1 && own_n[b] == -1) pk = b;
      if (elig[cli] && pk >= 0) begin
        e_gnt[cli] = 1'b1; e_idx[cli] = pk; own_n[pk] = -2 - cli; e_ptr = (cli + 1) % M;
      end
    end
    for (int c = 0; c < M; c++) begin
      if (rv[c]) begin
        if (m_own[ri[c]] == c) own_n[ri[c]] = rm[c] ? dest_of(c) : -1;
        else e_err[c] = 1'b1;
      end
    end
    for (int b = 0; b < N; b++) if (own_n[b] <= -2) own_n[b] = -2 - own_n[b];
    e_free = 0;
    for (int b = 0; b < N; b++) if (own_n[b] == -1) e_free++;
    @(posedge clk); #1;
    bad = (gnt_o != e_gnt) || (err_o != e_err) || (int'(free_cnt_o) != e_free);
    for (int c = 0; c < M; c++)
      if (e_gnt[c] && int'(gnt_idx_o[c*BW +: BW]) != e_idx[c]) bad = 1'b1;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: gnt=%b exp %b idx=%h exp %0d/%0d/%0d/%0d err=%b exp %b free=%0d exp %0d",
               tag, gnt_o, e_gnt, gnt_idx_o, e_idx[3], e_idx[2], e_idx[1], e_idx[0],
               err_o, e_err, free_cnt_o, e_free);
    end
    for (int b = 0; b < N; b++) m_own[b] = own_n[b];
    m_ptr = e_ptr; m_gprev = e_gnt;
    pend = pend & ~(gnt_o & ~sticky);
    rv = '0; rm = '0;
  endtask

  task automatic release_all(string tag);
    int b;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < M; c++) begin
        b = owned_by(c);
        if (b >= 0) begin rv[c] = 1'b1; ri[c] = b; end
      end
      step(tag);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int b;
    for (int i = 0; i < N; i++) m_own[i] = -1;
    for (int c = 0; c < M; c++) ri[c] = 0;
    m_ptr = 0; m_gprev = '0; pend = '0; sticky = '0; rv = '0; rm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    checks++;
    if (gnt_o != '0 || err_o != '0 || int'(free_cnt_o) != N) begin
      fails++;
      $display("FAIL R1: gnt=%b err=%b free=%0d exp 0/0/%0d", gnt_o, err_o, free_cnt_o, N);
    end
    step("R1");
    pend = 4'b0001; step("R2"); step("R2");
    pend |= 4'b0110; step("R9"); step("R9");
    pend |= 4'b0010; step("R8");
    pend |= 4'b1101; step("R3"); step("R3"); step("R3");
    rv = 4'b0001; rm = 4'b0000; ri[0] = 0; step("R5");
    step("R4");
    step("R10");
    rv = 4'b0010; rm = 4'b0010; ri[1] = 1; step("R6");
    rv = 4'b0010; rm = 4'b0000; ri[1] = 1; step("R7");
    rv = 4'b0100; rm = 4'b0000; ri[2] = 1; step("R6");
    step("R10");
    rv = 4'b1000; rm = 4'b1000; ri[3] = 0; step("R7");
    release_all("R5");
    step("R4"); step("R12");
    release_all("R12");
    sticky = 4'b0001; pend |= 4'b0001;
    repeat (6) step("R11");
    sticky = '0; step("R11");
    release_all("R5");
    pend = 4'b1111; step("R9"); step("R9");
    pend = 4'b1111; step("R3"); step("R3");
    for (int r = 0; r < 4; r++) begin
      b = owned_by(r);
      if (b >= 0) begin rv[r] = 1'b1; rm[r] = 1'b0; ri[r] = b; end
      step("R10"); step("R10");
    end
    release_all("R12");
    step("R12");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule